// File: doc/BRIEF.md
# Cache-Line Access Splitter

This block takes a single memory access, described by a start address, a byte count, a per-byte enable mask and an access kind (load, store or atomic), and breaks it into sub-requests that each stay inside one aligned cache line. Each sub-request carries its own address, its byte count and the part of the enable mask that belongs to its bytes. Sub-requests leave on a valid/ready stream, in ascending address order. The final one carries a last marker.

Sub-requests whose enable slice has no active byte are dropped before they reach the stream. If every sub-request is dropped, the access is reported as needing no memory traffic. An atomic access that would need more than one line is illegal: it is reported on an error pulse and yields nothing. A response input counts one returning response per issued sub-request. A completion pulse fires once the last sub-request has gone out and every issued one has been answered. The block takes a new access only when it is fully idle.

The line size and the largest access size are parameters.

Top module: `line_splitter`

## Requirements
- R1: Fragment geometry. The first fragment starts at `acc_addr` and ends at the next line boundary or at the end of the access, whichever comes first. Each later fragment starts on a line boundary. All fragments but the last are full lines. The last one holds the remaining bytes. `frag_len` is the fragment's byte count.
- R2: `acc_be` bit i enables access byte `acc_addr+i`. Bits at or above `acc_len` are ignored. `frag_be` bit j enables byte `frag_addr+j`. Bits at or above `frag_len` are zero.
- R3: A fragment whose enable slice is all zero is skipped. The surviving fragments come out in ascending address order. `frag_last` is 1 on the final surviving fragment only. No fragment follows it.
- R4: If no fragment survives, no fragment is emitted. `acc_nomem` is high for exactly the one cycle after acceptance, and `acc_done` does not fire.
- R5: Kind encoding is 2'b00 load, 2'b01 store, 2'b10 atomic, 2'b11 treated as a load. For an atomic access that spans more than one line, `acc_err` is high for exactly the one cycle after acceptance, and no fragment is produced. An atomic access inside one line is split normally.
- R6: The first fragment is valid in the cycle after acceptance. While `frag_valid` is high and `frag_ready` is low, the fragment's fields stay unchanged.
- R7: `acc_ready` is low from the cycle after a memory-needing access is accepted until its completion pulse. An access is accepted on a cycle where `acc_valid` and `acc_ready` are both high.
- R8: Each cycle with `rsp_valid` high counts as one returned fragment. A response that arrives when nothing is outstanding is ignored. `acc_done` is high for one cycle, in the cycle after the last fragment has been issued and the returned count has reached the issued count.
- R9: After reset, `acc_ready` is 1 and `frag_valid`, `acc_err`, `acc_nomem` and `acc_done` are 0.
- R10: `frag_kind` repeats the kind of the access being split.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Block idle, access can be taken |
| acc_addr | input | ADDR_W | Byte address of the first byte |
| acc_len | input | LEN_W | Byte count, 1..MAX_BYTES |
| acc_be | input | MAX_BYTES | Per-byte enable, bit i for byte acc_addr+i |
| acc_kind | input | 2 | Access kind (R5 encoding) |
| acc_err | output | 1 | Illegal atomic crossing pulse |
| acc_nomem | output | 1 | No surviving fragment pulse |
| frag_valid | output | 1 | Fragment offered |
| frag_ready | input | 1 | Fragment taken by the consumer |
| frag_addr | output | ADDR_W | Fragment start address |
| frag_len | output | FLEN_W | Fragment byte count |
| frag_be | output | LINE_BYTES | Fragment byte enables, bit j for frag_addr+j |
| frag_kind | output | 2 | Kind of the parent access |
| frag_last | output | 1 | Final surviving fragment |
| rsp_valid | input | 1 | One fragment response returned |
| acc_done | output | 1 | All issued fragments answered |

## Verification
The splitting is tried on four shapes of access: an aligned full line, an unaligned access inside one line, a two-line straddle, and a maximum-size access spread over five lines. Together they separate a wrong first-fragment length, a wrong middle step and a wrong tail. The same five-line access is then sent with sparse enables, to show that empty middle fragments are dropped and that the last marker moves to the last survivor. An all-zero mask, enables set beyond the length, and atomic accesses both inside and across a line separate the filtering, the masking and the rejection paths. A stalling consumer and a stray response while idle check that the stream holds its fields and that the response counter is not corrupted.

// File: rtl/line_split_pkg.sv
// Shared types and sizing helpers for the cache-line access splitter.
package line_split_pkg;

    // Access kind carried with every access and fragment.
    typedef enum logic [1:0] {
        KIND_LOAD   = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_ATOMIC = 2'b10,
        KIND_RSVD   = 2'b11
    } acc_kind_e;

    // Upper bound on the fragments one access can produce.
    function automatic int frag_slots(input int max_bytes, input int line_bytes);
        return max_bytes / line_bytes + 1;
    endfunction

endpackage

// File: rtl/line_frag_geom.sv
// Computes one fragment of an access: its address, length and enable slice.
// Assumes LINE_BYTES is a power of two >= 2 and MAX_BYTES >= LINE_BYTES.
// Purely combinational; idx selects which fragment (0 = the leading one).
module line_frag_geom #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_BYTES  = 64,
    parameter int IDX_W      = 3,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int FLEN_W    = $clog2(LINE_BYTES + 1)
) (
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [LEN_W-1:0]      base_len,
    input  logic [MAX_BYTES-1:0]  base_be,
    input  logic [IDX_W-1:0]      idx,
    output logic [ADDR_W-1:0]     f_addr,
    output logic [FLEN_W-1:0]     f_len,
    output logic [LINE_BYTES-1:0] f_be,
    output logic                  f_exists
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int OW    = LEN_W + 2;

    logic [OW-1:0]        lead;
    logic [OW-1:0]        start_o;
    logic [OW-1:0]        end_o;
    logic [OW-1:0]        len_x;
    logic [OW-1:0]        stop_o;
    logic [OW-1:0]        flen_x;
    logic [MAX_BYTES-1:0] be_in_len;
    logic [MAX_BYTES-1:0] be_shift;

    // Byte offsets (within the access) where this fragment starts and stops.
    always_comb begin
        lead     = OW'(LINE_BYTES) - OW'(base_addr[OFS_W-1:0]);
        len_x    = OW'(base_len);
        start_o  = (idx == '0) ? '0 : lead + (OW'(idx) - OW'(1)) * OW'(LINE_BYTES);
        end_o    = lead + OW'(idx) * OW'(LINE_BYTES);
        stop_o   = (end_o < len_x) ? end_o : len_x;
        f_exists = start_o < len_x;
        flen_x   = f_exists ? (stop_o - start_o) : '0;
        f_len    = FLEN_W'(flen_x);
    end

    // Start address: the access address for the leading piece, else a line base.
    always_comb begin
        if (idx == '0) f_addr = base_addr;
        else           f_addr = {base_addr[ADDR_W-1:OFS_W], OFS_W'(0)}
                                + ADDR_W'(idx) * ADDR_W'(LINE_BYTES);
    end

    // Enable slice: drop bits past the access length, then cut out this fragment.
    always_comb begin
        for (int i = 0; i < MAX_BYTES; i++) be_in_len[i] = base_be[i] && (OW'(i) < len_x);
        be_shift = be_in_len >> start_o;
        for (int j = 0; j < LINE_BYTES; j++) f_be[j] = be_shift[j] && (OW'(j) < flen_x);
    end
endmodule

// File: rtl/line_frag_planner.sv
// Evaluates every fragment slot of an access in parallel and flags the ones
// worth sending (present and with at least one enabled byte).
// Assumes NSLOT >= 2 so that slot 1 tells whether the access crosses a line.
module line_frag_planner #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_BYTES  = 64,
    parameter int NSLOT      = 5,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int FLEN_W    = $clog2(LINE_BYTES + 1),
    localparam int IDX_W     = $clog2(NSLOT)
) (
    input  logic [ADDR_W-1:0]                 in_addr,
    input  logic [LEN_W-1:0]                  in_len,
    input  logic [MAX_BYTES-1:0]              in_be,
    output logic [NSLOT-1:0][ADDR_W-1:0]      slot_addr,
    output logic [NSLOT-1:0][FLEN_W-1:0]      slot_len,
    output logic [NSLOT-1:0][LINE_BYTES-1:0]  slot_be,
    output logic [NSLOT-1:0]                  slot_keep,
    output logic                              crosses
);
    logic [NSLOT-1:0] slot_exists;

    // One geometry unit per slot, each with a fixed index.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        line_frag_geom #(
            .ADDR_W    (ADDR_W),
            .LINE_BYTES(LINE_BYTES),
            .MAX_BYTES (MAX_BYTES),
            .IDX_W     (IDX_W)
        ) u_geom (
            .base_addr(in_addr),
            .base_len (in_len),
            .base_be  (in_be),
            .idx      (IDX_W'(g)),
            .f_addr   (slot_addr[g]),
            .f_len    (slot_len[g]),
            .f_be     (slot_be[g]),
            .f_exists (slot_exists[g])
        );
        // A slot survives only if it exists and enables some byte.
        assign slot_keep[g] = slot_exists[g] && (|slot_be[g]);
    end

    // More than one slot present means the access straddles a line boundary.
    assign crosses = slot_exists[1];
endmodule

// File: rtl/line_rsp_tracker.sv
// Counts issued fragments against returned responses and pulses done once
// the final fragment of an access has been issued and all are answered.
// Assumes at most one issue and one response per cycle.
module line_rsp_tracker #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic issue_last,
    input  logic rsp,
    output logic done,
    output logic idle
);
    logic [CNT_W-1:0] outstanding;
    logic [CNT_W-1:0] cnt_nxt;
    logic             all_sent;
    logic             sent_nxt;
    logic             rsp_take;

    // Next count; a response with nothing in flight is dropped.
    always_comb begin
        rsp_take = rsp && ((outstanding != '0) || issue);
        cnt_nxt  = outstanding + CNT_W'(issue) - CNT_W'(rsp_take);
        sent_nxt = all_sent || issue_last;
    end

    // Count register, issued-all flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
            all_sent    <= 1'b0;
            done        <= 1'b0;
        end else begin
            outstanding <= cnt_nxt;
            if (sent_nxt && (cnt_nxt == '0)) begin
                done     <= 1'b1;
                all_sent <= 1'b0;
            end else begin
                done     <= 1'b0;
                all_sent <= sent_nxt;
            end
        end
    end

    assign idle = (outstanding == '0) && !all_sent;
endmodule

// File: rtl/line_splitter.sv
// Top of the cache-line access splitter. Takes one access when idle, plans
// all its line fragments in the accept cycle, stores the surviving ones in
// a slot table and streams them out lowest slot first. Rejects atomics that
// cross a line and flags accesses with no enabled fragment.
// Assumes acc_len is 1..MAX_BYTES and LINE_BYTES is a power of two.
module line_splitter
    import line_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_BYTES  = 64,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int FLEN_W    = $clog2(LINE_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    output logic                  acc_ready,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [LEN_W-1:0]      acc_len,
    input  logic [MAX_BYTES-1:0]  acc_be,
    input  logic [1:0]            acc_kind,
    output logic                  acc_err,
    output logic                  acc_nomem,
    output logic                  frag_valid,
    input  logic                  frag_ready,
    output logic [ADDR_W-1:0]     frag_addr,
    output logic [FLEN_W-1:0]     frag_len,
    output logic [LINE_BYTES-1:0] frag_be,
    output logic [1:0]            frag_kind,
    output logic                  frag_last,
    input  logic                  rsp_valid,
    output logic                  acc_done
);
    localparam int NSLOT = frag_slots(MAX_BYTES, LINE_BYTES);
    localparam int IDX_W = $clog2(NSLOT);
    localparam int CNT_W = $clog2(NSLOT + 1);

    logic [NSLOT-1:0][ADDR_W-1:0]     pl_addr;
    logic [NSLOT-1:0][FLEN_W-1:0]     pl_len;
    logic [NSLOT-1:0][LINE_BYTES-1:0] pl_be;
    logic [NSLOT-1:0]                 pl_keep;
    logic                             pl_cross;

    logic [NSLOT-1:0][ADDR_W-1:0]     tbl_addr;
    logic [NSLOT-1:0][FLEN_W-1:0]     tbl_len;
    logic [NSLOT-1:0][LINE_BYTES-1:0] tbl_be;
    logic [NSLOT-1:0]                 pend;
    logic [1:0]                       kind_q;
    logic                             busy;
    logic                             err_q;
    logic                             nomem_q;

    logic                             accept;
    logic                             illegal;
    logic                             launch;
    logic [IDX_W-1:0]                 cur;
    logic                             cur_last;
    logic                             frag_fire;
    logic                             trk_idle;

    // Plan all fragments of the offered access.
    line_frag_planner #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES),
        .MAX_BYTES (MAX_BYTES),
        .NSLOT     (NSLOT)
    ) u_plan (
        .in_addr  (acc_addr),
        .in_len   (acc_len),
        .in_be    (acc_be),
        .slot_addr(pl_addr),
        .slot_len (pl_len),
        .slot_be  (pl_be),
        .slot_keep(pl_keep),
        .crosses  (pl_cross)
    );

    // Accept decode: illegal atomics and empty plans never start streaming.
    always_comb begin
        accept  = acc_valid && acc_ready;
        illegal = (acc_kind == KIND_ATOMIC) && pl_cross;
        launch  = accept && !illegal && (pl_keep != '0);
    end

    // Lowest pending slot is the next fragment to send.
    always_comb begin
        cur = '0;
        for (int k = NSLOT - 1; k >= 0; k--) begin
            if (pend[k]) cur = IDX_W'(k);
        end
        cur_last = (pend & (pend - NSLOT'(1))) == '0;
    end

    // Slot table capture on launch, kept until overwritten by the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_addr <= '0;
            tbl_len  <= '0;
            tbl_be   <= '0;
            kind_q   <= '0;
        end else if (launch) begin
            tbl_addr <= pl_addr;
            tbl_len  <= pl_len;
            tbl_be   <= pl_be;
            kind_q   <= acc_kind;
        end
    end

    // Pending mask and busy flag; one slot retires per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            busy <= 1'b0;
        end else if (launch) begin
            pend <= pl_keep;
            busy <= 1'b1;
        end else if (frag_fire) begin
            pend <= pend & ~(NSLOT'(1) << cur);
            if (cur_last) busy <= 1'b0;
        end
    end

    // One-cycle status pulses for rejected and memory-free accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            nomem_q <= 1'b0;
        end else begin
            err_q   <= accept && illegal;
            nomem_q <= accept && !illegal && (pl_keep == '0);
        end
    end

    // Response bookkeeping and completion.
    line_rsp_tracker #(
        .CNT_W(CNT_W)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (frag_fire),
        .issue_last(frag_fire && cur_last),
        .rsp       (rsp_valid),
        .done      (acc_done),
        .idle      (trk_idle)
    );

    assign frag_fire  = busy && frag_ready;
    assign acc_ready  = !busy && trk_idle;
    assign acc_err    = err_q;
    assign acc_nomem  = nomem_q;
    assign frag_valid = busy;
    assign frag_addr  = tbl_addr[cur];
    assign frag_len   = tbl_len[cur];
    assign frag_be    = tbl_be[cur];
    assign frag_kind  = kind_q;
    assign frag_last  = cur_last;
endmodule

// File: rtl/line_splitter_chk.sv
// Protocol and geometry checks for line_splitter, attached by bind.
// Observes ports only.
module line_splitter_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int FLEN_W     = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_ready,
    input logic                  acc_err,
    input logic                  acc_nomem,
    input logic                  frag_valid,
    input logic                  frag_ready,
    input logic [ADDR_W-1:0]     frag_addr,
    input logic [FLEN_W-1:0]     frag_len,
    input logic [LINE_BYTES-1:0] frag_be,
    input logic                  frag_last,
    input logic                  acc_done
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    // R1: a fragment is non-empty and stays inside its line.
    p_in_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> (frag_len != '0) &&
        ((int'(frag_addr[OFS_W-1:0]) + int'(frag_len)) <= LINE_BYTES));

    // R2: no enable bit beyond the fragment length.
    p_be_in_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> ((frag_be >> frag_len) == '0));

    // R3: every emitted fragment enables some byte.
    p_be_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> (frag_be != '0));

    // R3: the fragment after a non-last one lies at a higher address.
    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && frag_ready && !frag_last) |=>
        (frag_valid && (frag_addr > $past(frag_addr))));

    // R5: a rejected access produces no fragment and no nomem pulse.
    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (!frag_valid && !acc_nomem));

    // R6: a stalled fragment holds its fields.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && !frag_ready) |=>
        (frag_valid && $stable(frag_addr) && $stable(frag_len) && $stable(frag_be)));

    // R7: no new access while fragments are being streamed.
    p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> !acc_ready);

    // R8: completion is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);
endmodule

bind line_splitter line_splitter_chk #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .FLEN_W    (FLEN_W)
) u_chk (.*);

// File: tb/tb_line_splitter.sv
`timescale 1ns/1ps
// Directed bench for line_splitter: one task per scenario.
module tb_line_splitter;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 16;
    localparam int MAX_BYTES  = 64;
    localparam int LEN_W      = $clog2(MAX_BYTES + 1);
    localparam int FLEN_W     = $clog2(LINE_BYTES + 1);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  acc_valid = 1'b0;
    logic                  acc_ready;
    logic [ADDR_W-1:0]     acc_addr = '0;
    logic [LEN_W-1:0]      acc_len = '0;
    logic [MAX_BYTES-1:0]  acc_be = '0;
    logic [1:0]            acc_kind = '0;
    logic                  acc_err;
    logic                  acc_nomem;
    logic                  frag_valid;
    logic                  frag_ready = 1'b0;
    logic [ADDR_W-1:0]     frag_addr;
    logic [FLEN_W-1:0]     frag_len;
    logic [LINE_BYTES-1:0] frag_be;
    logic [1:0]            frag_kind;
    logic                  frag_last;
    logic                  rsp_valid = 1'b0;
    logic                  acc_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] e_addr [8];
    int          e_len  [8];
    logic [15:0] e_be   [8];
    int          e_n;

    line_splitter #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)) dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Byte-by-byte model of the expected fragment list.
    task automatic compute_exp(input logic [31:0] a, input int len, input logic [63:0] be);
        logic [31:0] ra [8];
        int          rl [8];
        logic [15:0] rb [8];
        int          rn = 0;
        logic [31:0] line_id = '0;
        for (int i = 0; i < len; i++) begin
            logic [31:0] b;
            b = a + 32'(i);
            if (rn == 0 || (b / LINE_BYTES) != line_id) begin
                rn++;
                ra[rn-1] = b;
                rl[rn-1] = 0;
                rb[rn-1] = '0;
                line_id  = b / LINE_BYTES;
            end
            rb[rn-1][rl[rn-1]] = be[i];
            rl[rn-1]++;
        end
        e_n = 0;
        for (int k = 0; k < rn; k++) begin
            if (rb[k] != '0) begin
                e_addr[e_n] = ra[k];
                e_len[e_n]  = rl[k];
                e_be[e_n]   = rb[k];
                e_n++;
            end
        end
    endtask

    // Offers one access; returns at the negedge after acceptance.
    task automatic send_access(input logic [31:0] a, input int len, input logic [63:0] be,
                               input logic [1:0] kind, input string req);
        @(negedge clk);
        check(acc_ready == 1'b1, req, "acc_ready before access", acc_ready, 1);
        acc_valid = 1'b1;
        acc_addr  = a;
        acc_len   = LEN_W'(len);
        acc_be    = be;
        acc_kind  = kind;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Drains the fragment stream, optionally stalling every other cycle.
    task automatic collect(input bit stall, input logic [1:0] kind, input string req);
        int got = 0;
        for (int c = 0; got < e_n && c < 40; c++) begin
            bit rdy;
            bit was_valid;
            rdy = stall ? (c % 2 == 1) : 1'b1;
            was_valid = frag_valid;
            check(frag_valid == 1'b1, req, "frag_valid", frag_valid, 1);
            if (frag_valid) begin
                check(frag_addr == e_addr[got], req, "frag_addr", frag_addr, e_addr[got]);
                check(int'(frag_len) == e_len[got], req, "frag_len", frag_len, e_len[got]);
                check(frag_be == e_be[got], req, "frag_be", frag_be, e_be[got]);
                check(frag_last == (got == e_n - 1), req, "frag_last", frag_last, got == e_n - 1);
                check(frag_kind == kind, "R10", "frag_kind", frag_kind, kind);
            end
            frag_ready = rdy;
            @(negedge clk);
            if (rdy && was_valid) got++;
        end
        frag_ready = 1'b0;
        check(frag_valid == 1'b0, "R3", "no fragment after last", frag_valid, 0);
        check(acc_ready == 1'b0, "R7", "acc_ready while responses owed", acc_ready, 0);
    endtask

    // Returns one response per fragment and checks the completion pulse.
    task automatic respond(input int n);
        for (int i = 0; i < n; i++) begin
            check(acc_done == 1'b0, "R8", "acc_done before final response", acc_done, 0);
            rsp_valid = 1'b1;
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        check(acc_done == 1'b1, "R8", "acc_done after final response", acc_done, 1);
        @(negedge clk);
        check(acc_done == 1'b0, "R8", "acc_done one cycle", acc_done, 0);
        check(acc_ready == 1'b1, "R7", "acc_ready after completion", acc_ready, 1);
    endtask

    task automatic run_normal(input logic [31:0] a, input int len, input logic [63:0] be,
                              input logic [1:0] kind, input bit stall, input string req);
        compute_exp(a, len, be);
        send_access(a, len, be, kind, req);
        check(acc_nomem == 1'b0 && acc_err == 1'b0, req, "no status pulse", {acc_err, acc_nomem}, 0);
        collect(stall, kind, req);
        respond(e_n);
    endtask

    task automatic t_reset();
        check(acc_ready == 1'b1, "R9", "acc_ready at reset", acc_ready, 1);
        check(frag_valid == 1'b0, "R9", "frag_valid at reset", frag_valid, 0);
        check({acc_err, acc_nomem, acc_done} == 3'b000, "R9", "pulses at reset",
              {acc_err, acc_nomem, acc_done}, 0);
    endtask

    task automatic t_aligned_line();
        run_normal(32'h100, 16, 64'hFFFF, 2'b00, 1'b0, "R1");
    endtask

    task automatic t_unaligned_in_line();
        run_normal(32'h104, 8, 64'hFF, 2'b00, 1'b0, "R1");
    endtask

    task automatic t_two_lines();
        run_normal(32'h10C, 8, 64'hFF, 2'b00, 1'b0, "R1");
    endtask

    task automatic t_five_lines_stalled();
        run_normal(32'h1007, 64, '1, 2'b00, 1'b1, "R6");
    endtask

    task automatic t_sparse_enables();
        run_normal(32'h1007, 64, 64'hF000_0000_0000_0007, 2'b00, 1'b0, "R3");
    endtask

    task automatic t_be_past_len();
        run_normal(32'h200, 4, '1, 2'b00, 1'b0, "R2");
    endtask

    task automatic t_store_kind();
        run_normal(32'h21E, 5, 64'h1B, 2'b01, 1'b0, "R10");
    endtask

    task automatic t_no_enables();
        send_access(32'h1007, 40, '0, 2'b00, "R4");
        check(acc_nomem == 1'b1, "R4", "acc_nomem pulse", acc_nomem, 1);
        check(frag_valid == 1'b0, "R4", "no fragment", frag_valid, 0);
        @(negedge clk);
        check(acc_nomem == 1'b0, "R4", "acc_nomem one cycle", acc_nomem, 0);
        check(acc_done == 1'b0 && frag_valid == 1'b0, "R4", "no done, no fragment",
              {acc_done, frag_valid}, 0);
        check(acc_ready == 1'b1, "R4", "ready after nomem", acc_ready, 1);
    endtask

    task automatic t_atomic_cross();
        send_access(32'h30C, 8, 64'hFF, 2'b10, "R5");
        check(acc_err == 1'b1, "R5", "acc_err pulse", acc_err, 1);
        check(frag_valid == 1'b0, "R5", "no fragment on error", frag_valid, 0);
        @(negedge clk);
        check(acc_err == 1'b0, "R5", "acc_err one cycle", acc_err, 0);
        check(frag_valid == 1'b0 && acc_ready == 1'b1, "R5", "idle after error",
              {frag_valid, acc_ready}, 1);
    endtask

    task automatic t_atomic_in_line();
        run_normal(32'h300, 8, 64'hFF, 2'b10, 1'b0, "R5");
    endtask

    task automatic t_stray_response();
        @(negedge clk);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        check(acc_done == 1'b0, "R8", "stray response gives no done", acc_done, 0);
        check(acc_ready == 1'b1, "R8", "stray response keeps idle", acc_ready, 1);
        run_normal(32'h40F, 2, 64'h3, 2'b00, 1'b0, "R8");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aligned_line();
        t_unaligned_in_line();
        t_two_lines();
        t_five_lines_stalled();
        t_sparse_enables();
        t_be_past_len();
        t_store_kind();
        t_no_enables();
        t_atomic_cross();
        t_atomic_in_line();
        t_stray_response();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule